// File: doc/BRIEF.md
# Content Protection Link Supervision Sequencer

This block supervises the content-protection state of one downstream display link. After reset, and again after every re-authentication, it probes the sink over an auxiliary-channel command engine. It reads the newer-version capability byte first and falls back to the older-version byte. From the results it classes the sink as version 2, version 1 or not capable. It keeps the upstream repeater indication in step with that class. Key exchange and list content checks are done elsewhere: an external authenticator is started through a request/done pair, and list validity arrives as a single bit.

Once authenticated, the sequencer turns each content-protection interrupt into a status check that depends on the version. Version 2 reads a status byte and honours its re-authentication request flag. Version 1 compares a two-byte link integrity value from the sink against the local one. In both versions a repeater that reports its list as ready has the list read and verified, then forwarded upstream. Encryption is enabled only when the whole authentication, including any list forwarding, has finished. Any failure drops encryption and restarts from capability detection.

Top module: `cp_link_supervisor`

## Requirements
- R1: After reset and after every re-authentication, the first auxiliary read targets the version-2 capability address. The version-1 capability address is read next only when the version-2 read did not report capable.
- R2: The version-2 capability byte reports capable on bit 1 and downstream-repeater on bit 0. The version-1 capability byte reports capable on bit 0, repeater on bit 1 and list-ready on bit 2. A read that ends with the error flag counts as not capable. A capable result raises auth_req_o with auth_ver_o = 2 or 1. Not capable on both leaves the block idle with no auth request.
- R3: rpt_up_o becomes 1 when the class changes from not capable to capable, and 0 when it changes from capable to not capable. It is 0 after reset.
- R4: Each auxiliary read holds aux_req_o with a stable address and byte count until aux_ack_i. The byte count is 1 for capability and status reads, 2 for the integrity value and LIST_LEN for lists.
- R5: In version-2 authenticated state, an interrupt causes a 1-byte status read. If bit 3 (re-authentication request) is 1, re-authentication follows. Otherwise, with no list pending, nothing changes.
- R6: In version 2 with a repeater downstream, status bit 0 (ready) starts a list read. list_ok_i = 1 then leads to an upstream forward via fwd_req_o/fwd_ack_i, and list_ok_i = 0 leads to re-authentication.
- R7: In version 1, an interrupt causes a 2-byte integrity read, with the first byte received as bits 7:0. A mismatch against ri_local_i causes re-authentication.
- R8: In version 1 with a repeater downstream and a matching integrity value, the capability byte is re-read. If its ready bit is set, the list is read. A valid list is forwarded upstream and an invalid one causes re-authentication.
- R9: enc_en_o rises only on a successful authentication result for a non-repeater sink, or on the acknowledge of an upstream list forward.
- R10: An interrupt that arrives while a check is running is held and served as soon as the sequencer returns to the authenticated state.
- R11: reauth_o is a one-cycle pulse. enc_en_o is 0 in that same cycle, and detection restarts with the version-2 capability read.
- R12: An auxiliary read ending with the error flag during a status, integrity, capability re-read or list read causes re-authentication.
- R13: redetect_i restarts detection: directly when idle and not capable, and through re-authentication when authenticated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redetect_i | input | 1 | Downstream plug or link event, requests a new probe |
| cp_irq_i | input | 1 | Content-protection interrupt pulse from the sink |
| ri_local_i | input | 16 | Local link integrity value |
| auth_req_o | output | 1 | Requests external authentication, held until done |
| auth_ver_o | output | 2 | Version class: 2, 1, or 0 for none |
| auth_done_i | input | 1 | Authentication finished strobe |
| auth_ok_i | input | 1 | Authentication result, valid with auth_done_i |
| list_ok_i | input | 1 | List valid with no topology error, sampled after a list read |
| fwd_req_o | output | 1 | Requests the upstream list message write |
| fwd_ack_i | input | 1 | Upstream list message written |
| aux_req_o | output | 1 | Auxiliary read request |
| aux_addr_o | output | AW | Auxiliary register address |
| aux_len_o | output | LW | Auxiliary byte count |
| aux_ack_i | input | 1 | Request accepted |
| aux_rvalid_i | input | 1 | Response byte strobe |
| aux_rdata_i | input | 8 | Response byte |
| aux_rerr_i | input | 1 | Response error, ends the read |
| enc_en_o | output | 1 | Encryption enable |
| rpt_up_o | output | 1 | Upstream repeater indication |
| reauth_o | output | 1 | Re-authentication pulse |

## Verification
The properties assume a well-behaved command engine. It acknowledges only a pending request, then returns exactly the requested number of bytes, one per valid strobe, or fewer when one carries the error flag. They also assume auth_done_i is pulsed only while auth_req_o is high and fwd_ack_i only while fwd_req_o is high. The bench's responder model keeps to these rules: it answers a request only after seeing it, sends the bytes on consecutive cycles and stops at the first error. Its authentication and forward replies are single-cycle pulses given only while the matching request is visible.

// File: rtl/cp_sup_pkg.sv
package cp_sup_pkg;

  typedef enum logic [3:0] {
    ST_CAP2,
    ST_CAP1,
    ST_NONE,
    ST_AUTH,
    ST_AUTHED,
    ST_STAT2,
    ST_RI,
    ST_BCAPS,
    ST_LIST,
    ST_LCHK,
    ST_FWD,
    ST_REAUTH
  } sup_state_e;

  typedef enum logic [1:0] {
    VER_NONE = 2'd0,
    VER_1    = 2'd1,
    VER_2    = 2'd2
  } cp_ver_e;

  // bit positions inside returned bytes
  localparam int V2_CAP_BIT    = 1;
  localparam int V2_RPT_BIT    = 0;
  localparam int V1_CAP_BIT    = 0;
  localparam int V1_RPT_BIT    = 1;
  localparam int V1_RDY_BIT    = 2;
  localparam int ST_RDY_BIT    = 0;
  localparam int ST_REAUTH_BIT = 3;

endpackage

// File: rtl/cp_aux_reader.sv
module cp_aux_reader #(
  parameter int AW     = 20,
  parameter int LW     = 8,
  parameter int DBYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [LW-1:0]     len_i,
  output logic              aux_req_o,
  output logic [AW-1:0]     aux_addr_o,
  output logic [LW-1:0]     aux_len_o,
  input  logic              aux_ack_i,
  input  logic              aux_rvalid_i,
  input  logic [7:0]        aux_rdata_i,
  input  logic              aux_rerr_i,
  output logic              done_o,
  output logic              err_o,
  output logic [DBYTES*8-1:0] data_o
);

  typedef enum logic [1:0] {R_IDLE, R_REQ, R_DATA} rd_state_e;

  rd_state_e     st_q, st_d;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] cnt_q;
  logic          done_q, err_q;
  logic          load, last, finish;
  logic [7:0]    byte_q [DBYTES];

  assign load   = (st_q == R_IDLE) && go_i;
  assign last   = (cnt_q == len_q - LW'(1));
  assign finish = (st_q == R_DATA) && aux_rvalid_i && (aux_rerr_i || last);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      R_IDLE:  if (go_i) st_d = R_REQ;
      R_REQ:   if (aux_ack_i) st_d = R_DATA;
      R_DATA:  if (finish) st_d = R_IDLE;
      default: st_d = R_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= R_IDLE;
      addr_q <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= finish;
      if (load) begin
        addr_q <= addr_i;
        len_q  <= len_i;
        cnt_q  <= '0;
        err_q  <= 1'b0;
      end else if ((st_q == R_DATA) && aux_rvalid_i) begin
        cnt_q <= cnt_q + LW'(1);
        if (aux_rerr_i) err_q <= 1'b1;
      end
    end
  end

  for (genvar b = 0; b < DBYTES; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q[b] <= '0;
      end else if (load) begin
        byte_q[b] <= '0;
      end else if ((st_q == R_DATA) && aux_rvalid_i && !aux_rerr_i &&
                   (cnt_q == LW'(b))) begin
        byte_q[b] <= aux_rdata_i;
      end
    end
    assign data_o[b*8 +: 8] = byte_q[b];
  end

  assign aux_req_o  = (st_q == R_REQ);
  assign aux_addr_o = addr_q;
  assign aux_len_o  = len_q;
  assign done_o     = done_q;
  assign err_o      = err_q;

endmodule

// File: rtl/cp_irq_hold.sv
module cp_irq_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_i,
  input  logic take_i,
  input  logic flush_i,
  output logic pend_o
);

  logic pend_q, pend_d;

  // a new event in the same cycle as a take stays pending
  assign pend_d = irq_i | (pend_q & ~take_i & ~flush_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/cp_link_supervisor.sv
module cp_link_supervisor
  import cp_sup_pkg::*;
#(
  parameter int          AW         = 20,
  parameter int          LW         = 8,
  parameter int          LIST_LEN   = 10,
  parameter logic [19:0] CAP2_ADDR  = 20'h40010,
  parameter logic [19:0] CAP1_ADDR  = 20'h40020,
  parameter logic [19:0] STAT_ADDR  = 20'h40030,
  parameter logic [19:0] RI_ADDR    = 20'h40040,
  parameter logic [19:0] LIST2_ADDR = 20'h40050,
  parameter logic [19:0] LIST1_ADDR = 20'h40060
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redetect_i,
  input  logic          cp_irq_i,
  input  logic [15:0]   ri_local_i,
  output logic          auth_req_o,
  output logic [1:0]    auth_ver_o,
  input  logic          auth_done_i,
  input  logic          auth_ok_i,
  input  logic          list_ok_i,
  output logic          fwd_req_o,
  input  logic          fwd_ack_i,
  output logic          aux_req_o,
  output logic [AW-1:0] aux_addr_o,
  output logic [LW-1:0] aux_len_o,
  input  logic          aux_ack_i,
  input  logic          aux_rvalid_i,
  input  logic [7:0]    aux_rdata_i,
  input  logic          aux_rerr_i,
  output logic          enc_en_o,
  output logic          rpt_up_o,
  output logic          reauth_o
);

  localparam int DBYTES = 2;

  sup_state_e    state_q, state_d;
  cp_ver_e       ver_q, ver_d;
  logic          rpt_ds_q, rpt_ds_d;
  logic          rpt_up_q, rpt_up_d;
  logic          enc_q, enc_d;
  logic          rd_iss_q, rd_iss_d;
  logic          rd_state, rd_go, rd_done, rd_err;
  logic [AW-1:0] rd_addr;
  logic [LW-1:0] rd_len;
  logic [DBYTES*8-1:0] rd_data;
  logic          irq_pend, irq_take, irq_flush;

  cp_aux_reader #(.AW(AW), .LW(LW), .DBYTES(DBYTES)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_i        (rd_go),
    .addr_i      (rd_addr),
    .len_i       (rd_len),
    .aux_req_o   (aux_req_o),
    .aux_addr_o  (aux_addr_o),
    .aux_len_o   (aux_len_o),
    .aux_ack_i   (aux_ack_i),
    .aux_rvalid_i(aux_rvalid_i),
    .aux_rdata_i (aux_rdata_i),
    .aux_rerr_i  (aux_rerr_i),
    .done_o      (rd_done),
    .err_o       (rd_err),
    .data_o      (rd_data)
  );

  cp_irq_hold u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_i  (cp_irq_i),
    .take_i (irq_take),
    .flush_i(irq_flush),
    .pend_o (irq_pend)
  );

  assign rd_state = (state_q == ST_CAP2) || (state_q == ST_CAP1) ||
                    (state_q == ST_STAT2) || (state_q == ST_RI) ||
                    (state_q == ST_BCAPS) || (state_q == ST_LIST);
  assign rd_go    = rd_state && !rd_iss_q;
  assign rd_iss_d = rd_done ? 1'b0 : (rd_iss_q | rd_go);
  assign irq_flush = (state_q == ST_REAUTH);

  always_comb begin
    state_d  = state_q;
    ver_d    = ver_q;
    rpt_ds_d = rpt_ds_q;
    rpt_up_d = rpt_up_q;
    enc_d    = enc_q;
    irq_take = 1'b0;
    rd_addr  = AW'(CAP2_ADDR);
    rd_len   = LW'(1);
    unique case (state_q)
      ST_CAP2: begin
        if (rd_done) begin
          if (!rd_err && rd_data[V2_CAP_BIT]) begin
            ver_d    = VER_2;
            rpt_ds_d = rd_data[V2_RPT_BIT];
            rpt_up_d = 1'b1;
            state_d  = ST_AUTH;
          end else begin
            state_d = ST_CAP1;
          end
        end
      end
      ST_CAP1: begin
        rd_addr = AW'(CAP1_ADDR);
        if (rd_done) begin
          if (!rd_err && rd_data[V1_CAP_BIT]) begin
            ver_d    = VER_1;
            rpt_ds_d = rd_data[V1_RPT_BIT];
            rpt_up_d = 1'b1;
            state_d  = ST_AUTH;
          end else begin
            ver_d    = VER_NONE;
            rpt_ds_d = 1'b0;
            rpt_up_d = 1'b0;
            state_d  = ST_NONE;
          end
        end
      end
      ST_NONE: begin
        if (redetect_i) state_d = ST_CAP2;
      end
      ST_AUTH: begin
        if (auth_done_i) begin
          if (auth_ok_i) begin
            state_d = ST_AUTHED;
            if (!rpt_ds_q) enc_d = 1'b1;
          end else begin
            state_d = ST_REAUTH;
          end
        end
      end
      ST_AUTHED: begin
        if (redetect_i) begin
          state_d = ST_REAUTH;
        end else if (irq_pend) begin
          irq_take = 1'b1;
          state_d  = (ver_q == VER_2) ? ST_STAT2 : ST_RI;
        end
      end
      ST_STAT2: begin
        rd_addr = AW'(STAT_ADDR);
        if (rd_done) begin
          if (rd_err || rd_data[ST_REAUTH_BIT])          state_d = ST_REAUTH;
          else if (rpt_ds_q && rd_data[ST_RDY_BIT])      state_d = ST_LIST;
          else                                           state_d = ST_AUTHED;
        end
      end
      ST_RI: begin
        rd_addr = AW'(RI_ADDR);
        rd_len  = LW'(2);
        if (rd_done) begin
          if (rd_err || (rd_data != ri_local_i)) state_d = ST_REAUTH;
          else if (rpt_ds_q)                     state_d = ST_BCAPS;
          else                                   state_d = ST_AUTHED;
        end
      end
      ST_BCAPS: begin
        rd_addr = AW'(CAP1_ADDR);
        if (rd_done) begin
          if (rd_err)                  state_d = ST_REAUTH;
          else if (rd_data[V1_RDY_BIT]) state_d = ST_LIST;
          else                         state_d = ST_AUTHED;
        end
      end
      ST_LIST: begin
        rd_addr = (ver_q == VER_2) ? AW'(LIST2_ADDR) : AW'(LIST1_ADDR);
        rd_len  = LW'(LIST_LEN);
        if (rd_done) state_d = rd_err ? ST_REAUTH : ST_LCHK;
      end
      ST_LCHK: begin
        state_d = list_ok_i ? ST_FWD : ST_REAUTH;
      end
      ST_FWD: begin
        if (fwd_ack_i) begin
          enc_d   = 1'b1;
          state_d = ST_AUTHED;
        end
      end
      ST_REAUTH: begin
        state_d = ST_CAP2;
      end
      default: state_d = ST_CAP2;
    endcase
    // encryption falls on the edge that raises the re-authentication pulse
    if (state_d == ST_REAUTH) enc_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_CAP2;
      ver_q    <= VER_NONE;
      rpt_ds_q <= 1'b0;
      rpt_up_q <= 1'b0;
      enc_q    <= 1'b0;
      rd_iss_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      ver_q    <= ver_d;
      rpt_ds_q <= rpt_ds_d;
      rpt_up_q <= rpt_up_d;
      enc_q    <= enc_d;
      rd_iss_q <= rd_iss_d;
    end
  end

  assign auth_req_o = (state_q == ST_AUTH);
  assign auth_ver_o = ver_q;
  assign fwd_req_o  = (state_q == ST_FWD);
  assign reauth_o   = (state_q == ST_REAUTH);
  assign enc_en_o   = enc_q;
  assign rpt_up_o   = rpt_up_q;

endmodule

// File: rtl/cp_link_supervisor_chk.sv
module cp_link_supervisor_chk #(
  parameter int          AW        = 20,
  parameter int          LW        = 8,
  parameter logic [19:0] CAP2_ADDR = 20'h40010
) (
  input logic          clk,
  input logic          rst_n,
  input logic          auth_req_o,
  input logic [1:0]    auth_ver_o,
  input logic          auth_done_i,
  input logic          auth_ok_i,
  input logic          fwd_ack_i,
  input logic          aux_req_o,
  input logic [AW-1:0] aux_addr_o,
  input logic [LW-1:0] aux_len_o,
  input logic          aux_ack_i,
  input logic          enc_en_o,
  input logic          rpt_up_o,
  input logic          reauth_o
);

  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_req_o && !aux_ack_i) |=> (aux_req_o && $stable(aux_addr_o) && $stable(aux_len_o)));

  a_r4_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_req_o && aux_ack_i) |=> !aux_req_o);

  a_r2_ver_class: assert property (@(posedge clk) disable iff (!rst_n)
    auth_req_o |-> (auth_ver_o == 2'd1 || auth_ver_o == 2'd2));

  a_r3_rpt_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rpt_up_o) |-> auth_req_o);

  a_r9_enc_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enc_en_o) |-> ($past(auth_done_i && auth_ok_i) || $past(fwd_ack_i)));

  a_r11_reauth_enc: assert property (@(posedge clk) disable iff (!rst_n)
    reauth_o |-> !enc_en_o);

  a_r11_reauth_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reauth_o |=> !reauth_o);

  a_r1_reauth_probe: assert property (@(posedge clk) disable iff (!rst_n)
    reauth_o |=> ##1 (aux_req_o && aux_addr_o == AW'(CAP2_ADDR)));

endmodule

bind cp_link_supervisor cp_link_supervisor_chk #(
  .AW(AW), .LW(LW), .CAP2_ADDR(CAP2_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .auth_req_o (auth_req_o),
  .auth_ver_o (auth_ver_o),
  .auth_done_i(auth_done_i),
  .auth_ok_i  (auth_ok_i),
  .fwd_ack_i  (fwd_ack_i),
  .aux_req_o  (aux_req_o),
  .aux_addr_o (aux_addr_o),
  .aux_len_o  (aux_len_o),
  .aux_ack_i  (aux_ack_i),
  .enc_en_o   (enc_en_o),
  .rpt_up_o   (rpt_up_o),
  .reauth_o   (reauth_o)
);

// File: tb/sim_cp_link_supervisor.sv
`timescale 1ns/1ps
module sim_cp_link_supervisor;

  localparam int          AW = 20;
  localparam int          LW = 8;
  localparam int          LIST_LEN = 10;
  localparam logic [19:0] A_CAP2 = 20'h40010;
  localparam logic [19:0] A_CAP1 = 20'h40020;
  localparam logic [19:0] A_STAT = 20'h40030;
  localparam logic [19:0] A_RI   = 20'h40040;
  localparam logic [19:0] A_L2   = 20'h40050;
  localparam logic [19:0] A_L1   = 20'h40060;
  localparam logic [19:0] A_NONE = 20'hFFFFF;

  // row: [27:20] v2 caps byte, [19:12] v1 caps byte, [11:10] error select
  // (1 = v2 caps read, 2 = v1 caps read), [9:8] expected version,
  // [7] expected rpt_up_o, [6] expected enc_en_o after a good authentication
  localparam logic [27:0] TBL [0:6] = '{
    28'h02002C0, 28'h00011C0, 28'h02015C0, 28'h0001800,
    28'hFDFE000, 28'h0300280, 28'h0003180
  };

  logic clk = 1'b0;
  logic rst_n;
  logic redetect, cp_irq, auth_done, auth_ok, list_ok, fwd_ack;
  logic [15:0] ri_local;
  logic auth_req, fwd_req, aux_req, aux_ack, aux_rvalid, aux_rerr;
  logic enc_en, rpt_up, reauth;
  logic [1:0] auth_ver;
  logic [AW-1:0] aux_addr;
  logic [LW-1:0] aux_len;
  logic [7:0] aux_rdata;

  logic [7:0]  m_cap2, m_cap1, m_stat;
  logic [15:0] m_ri;
  logic [19:0] err_addr;
  logic [19:0] addr_log [0:7];
  int log_n, len_bad, ri_reads, stat_reads, l1_reads, l2_reads, fwd_cnt;
  int reauth_cnt, reauth_enc_bad;
  logic enc_last, enc_before, enc_at;
  int nchk = 0, nerr = 0;

  always #4 clk = ~clk;

  cp_link_supervisor #(
    .AW(AW), .LW(LW), .LIST_LEN(LIST_LEN),
    .CAP2_ADDR(A_CAP2), .CAP1_ADDR(A_CAP1), .STAT_ADDR(A_STAT),
    .RI_ADDR(A_RI), .LIST2_ADDR(A_L2), .LIST1_ADDR(A_L1)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .redetect_i(redetect), .cp_irq_i(cp_irq),
    .ri_local_i(ri_local), .auth_req_o(auth_req), .auth_ver_o(auth_ver),
    .auth_done_i(auth_done), .auth_ok_i(auth_ok), .list_ok_i(list_ok),
    .fwd_req_o(fwd_req), .fwd_ack_i(fwd_ack), .aux_req_o(aux_req),
    .aux_addr_o(aux_addr), .aux_len_o(aux_len), .aux_ack_i(aux_ack),
    .aux_rvalid_i(aux_rvalid), .aux_rdata_i(aux_rdata), .aux_rerr_i(aux_rerr),
    .enc_en_o(enc_en), .rpt_up_o(rpt_up), .reauth_o(reauth)
  );

  function automatic int exp_len(input logic [19:0] a);
    if (a == A_RI) return 2;
    if (a == A_L1 || a == A_L2) return LIST_LEN;
    return 1;
  endfunction

  function automatic logic [7:0] byte_for(input logic [19:0] a, input int i);
    if (a == A_CAP2) return m_cap2;
    if (a == A_CAP1) return m_cap1;
    if (a == A_STAT) return m_stat;
    if (a == A_RI)   return (i == 0) ? m_ri[7:0] : m_ri[15:8];
    return 8'hA5;
  endfunction

  // auxiliary command engine model
  initial begin
    logic [19:0] ca;
    int cl;
    aux_ack = 0; aux_rvalid = 0; aux_rdata = 0; aux_rerr = 0;
    forever begin
      @(negedge clk);
      if (aux_req) begin
        ca = aux_addr; cl = int'(aux_len);
        if (log_n < 8) addr_log[log_n] = ca;
        log_n++;
        if (cl != exp_len(ca)) len_bad++;
        if (ca == A_RI)   ri_reads++;
        if (ca == A_STAT) stat_reads++;
        if (ca == A_L1)   l1_reads++;
        if (ca == A_L2)   l2_reads++;
        aux_ack = 1;
        @(negedge clk);
        aux_ack = 0;
        for (int i = 0; i < cl; i++) begin
          aux_rvalid = 1;
          aux_rdata  = byte_for(ca, i);
          aux_rerr   = (ca == err_addr);
          @(negedge clk);
          if (aux_rerr) break;
        end
        aux_rvalid = 0; aux_rerr = 0;
      end
    end
  end

  // upstream forward model
  initial begin
    fwd_ack = 0;
    forever begin
      @(negedge clk);
      if (fwd_req && !fwd_ack) begin fwd_ack = 1; fwd_cnt++; end
      else fwd_ack = 0;
    end
  end

  // re-authentication monitor
  always @(negedge clk) begin
    if (rst_n && reauth) begin
      reauth_cnt++;
      enc_before = enc_last;
      enc_at     = enc_en;
      if (enc_en) reauth_enc_bad++;
    end
    enc_last = enc_en;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_irq();
    @(negedge clk) cp_irq = 1;
    @(negedge clk) cp_irq = 0;
  endtask

  task automatic pulse_redetect();
    @(negedge clk) redetect = 1;
    @(negedge clk) redetect = 0;
  endtask

  task automatic auth_reply(input bit ok);
    for (int i = 0; i < 100 && !auth_req; i++) @(negedge clk);
    @(negedge clk) begin auth_done = 1; auth_ok = ok; end
    @(negedge clk) begin auth_done = 0; auth_ok = 0; end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int rc, fc, rr;
    rst_n = 0; redetect = 0; cp_irq = 0; auth_done = 0; auth_ok = 0;
    list_ok = 0; ri_local = 16'h1234;
    m_cap2 = 0; m_cap1 = 0; m_stat = 0; m_ri = 16'h1234; err_addr = A_NONE;
    log_n = 0; len_bad = 0; ri_reads = 0; stat_reads = 0; l1_reads = 0; l2_reads = 0;
    fwd_cnt = 0; reauth_cnt = 0; reauth_enc_bad = 0; enc_last = 0; enc_before = 0; enc_at = 0;
    repeat (4) @(negedge clk);
    chk(!aux_req && !enc_en && !rpt_up && !reauth && !auth_req, "reset R3", 0, 0);
    rst_n = 1;
    repeat (40) @(negedge clk);
    chk(addr_log[0] == A_CAP2 && addr_log[1] == A_CAP1 && log_n == 2, "R1 after reset", log_n, 2);
    chk(!auth_req && !rpt_up, "R2 none after reset", auth_req, 0);

    for (int r = 0; r < 7; r++) begin
      logic [27:0] v;
      v = TBL[r];
      m_cap2 = v[27:20]; m_cap1 = v[19:12];
      err_addr = (v[11:10] == 2'd1) ? A_CAP2 : (v[11:10] == 2'd2) ? A_CAP1 : A_NONE;
      log_n = 0;
      pulse_redetect();
      repeat (40) @(negedge clk);
      chk(addr_log[0] == A_CAP2, "R1 R13 first probe", int'(addr_log[0]), int'(A_CAP2));
      if (v[9:8] == 2'd2) chk(log_n == 1, "R1 no v1 probe", log_n, 1);
      else chk(log_n == 2 && addr_log[1] == A_CAP1, "R1 v1 probe second", log_n, 2);
      chk(auth_req == (v[9:8] != 0), "R2 auth request", auth_req, int'(v[9:8] != 0));
      if (v[9:8] != 0) chk(auth_ver == v[9:8], "R2 version", auth_ver, v[9:8]);
      chk(rpt_up == v[7], "R3 repeater bit", rpt_up, v[7]);
      if (v[9:8] != 0) begin
        auth_reply(1'b1);
        chk(enc_en == v[6], "R9 enc after auth", enc_en, v[6]);
      end
      err_addr = A_NONE;
    end

    // v1 repeater, authenticated, encryption off
    m_cap1 = 8'h07; list_ok = 1; rc = reauth_cnt;
    pulse_irq();
    repeat (60) @(negedge clk);
    chk(ri_reads == 1, "R7 integrity read", ri_reads, 1);
    chk(l1_reads == 1 && fwd_cnt == 1, "R8 list forward", fwd_cnt, 1);
    chk(enc_en == 1, "R9 enc after forward", enc_en, 1);
    chk(reauth_cnt == rc, "R7 match no reauth", reauth_cnt, rc);

    m_cap1 = 8'h03; ri_reads = 0;
    pulse_irq();
    repeat (3) @(negedge clk);
    pulse_irq();
    repeat (80) @(negedge clk);
    chk(ri_reads == 2, "R10 pending irq served", ri_reads, 2);
    chk(reauth_cnt == rc && enc_en, "R10 no reauth", reauth_cnt, rc);

    ri_local = 16'h1235; log_n = 0;
    pulse_irq();
    repeat (60) @(negedge clk);
    chk(reauth_cnt == rc + 1, "R7 mismatch reauth", reauth_cnt, rc + 1);
    chk(enc_before == 1 && enc_at == 0, "R11 enc drop same cycle", enc_at, 0);
    chk(addr_log[1] == A_CAP2, "R11 probe restarts", int'(addr_log[1]), int'(A_CAP2));
    chk(auth_req && auth_ver == 2'd1, "R11 reclassified", auth_ver, 1);
    ri_local = 16'h1234;
    auth_reply(1'b1);
    chk(enc_en == 0, "R9 repeater waits for list", enc_en, 0);

    m_cap1 = 8'h07; list_ok = 0; rc = reauth_cnt; fc = fwd_cnt;
    pulse_irq();
    repeat (70) @(negedge clk);
    chk(reauth_cnt == rc + 1 && fwd_cnt == fc, "R8 invalid list", reauth_cnt, rc + 1);
    auth_reply(1'b1);

    // switch sink to v2 repeater
    m_cap2 = 8'h03; m_cap1 = 8'h00;
    pulse_redetect();
    repeat (40) @(negedge clk);
    chk(auth_req && auth_ver == 2'd2, "R13 redetect to v2", auth_ver, 2);
    auth_reply(1'b1);

    m_stat = 8'h08; rc = reauth_cnt; rr = stat_reads;
    pulse_irq();
    repeat (40) @(negedge clk);
    chk(stat_reads == rr + 1 && reauth_cnt == rc + 1, "R5 reauth request bit", reauth_cnt, rc + 1);
    auth_reply(1'b1);

    m_stat = 8'h01; list_ok = 1; fc = fwd_cnt;
    pulse_irq();
    repeat (60) @(negedge clk);
    chk(l2_reads == 1 && fwd_cnt == fc + 1, "R6 v2 list forward", fwd_cnt, fc + 1);
    chk(enc_en == 1, "R9 v2 enc after forward", enc_en, 1);

    m_stat = 8'h00; rc = reauth_cnt;
    pulse_irq();
    repeat (40) @(negedge clk);
    chk(reauth_cnt == rc && enc_en == 1, "R5 clear status no effect", reauth_cnt, rc);

    err_addr = A_STAT;
    pulse_irq();
    repeat (40) @(negedge clk);
    chk(reauth_cnt == rc + 1 && enc_en == 0, "R12 read error reauth", reauth_cnt, rc + 1);
    err_addr = A_NONE;
    auth_reply(1'b1);

    m_stat = 8'h01; list_ok = 0; rc = reauth_cnt;
    pulse_irq();
    repeat (60) @(negedge clk);
    chk(reauth_cnt == rc + 1, "R6 invalid v2 list", reauth_cnt, rc + 1);

    chk(len_bad == 0, "R4 byte counts", len_bad, 0);
    chk(reauth_enc_bad == 0, "R11 enc low in pulse", reauth_enc_bad, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule